// File: doc/BRIEF.md
# Chained Double-Window DMA Channel

This block is one DMA channel that moves data words between a peripheral stream port and a memory request port. It holds two address windows. The active window is a running address and an end address. The queued window is a start address and a stop address, which software loads ahead of time. When the running address reaches the end address, the channel looks at a software-armed update flag. If the flag is set, it copies the queued window into the active window in the same cycle and keeps moving data with no idle gap. If the flag is clear, it stops.

Each window end raises a level interrupt, which stays high until software clears the completion flag. At every window end and on a bus error, the final running address is captured into a saved-end register, so software can work out how far the transfer got. The direction is set by command bits. Read direction carries peripheral words into memory, and write direction carries memory words out to the peripheral. A one-word holding register sits between the two sides, and a start command can flush it.

Top module: `dbuf_dma_chan`

## Requirements
- R1: Register selects 1 to 8 map to running address, end address, queued start, queued stop, and then saved copies of running, end, start and stop. Each register is written and read back independently, and `reg_rdata` shows the selected register combinationally.
- R2: A write to select 0 is a command. Bit 0 is reset, bit 1 clears completion, bit 2 sets enable, bit 3 sets update, bit 4 selects read direction and bit 5 selects write direction. A command of all zeros changes nothing. A read of select 0 returns status: bit 0 enable, bit 1 update, bit 2 complete, bit 3 bus exception, bit 4 read direction.
- R3: After the reset pin, all status bits, all registers and all handshake outputs are zero. The reset command clears enable, update, complete and bus exception, and leaves the direction bit unchanged.
- R4: In read direction, a word taken on `per_in_valid`/`per_in_ready` is written to memory at the running address. In write direction, a word read from memory at the running address is offered on `per_out_valid`/`per_out_data`. Each accepted memory access without an error adds DATA_W/8 to the running address.
- R5: At a window end with update set, complete is set, the queued start and stop become the running and end addresses in the same cycle, update is cleared and enable stays set.
- R6: At a window end with update clear, complete is set and enable is cleared. At every window end, the saved end register takes the final running address.
- R7: `irq` is high exactly while complete is set. Only a command with clear-complete or reset lowers it, and the same command may set update again.
- R8: A memory response with `mem_err` high sets bus exception and complete, clears enable, and drops the held word. The running address and the saved end register then hold the faulting address.
- R9: A window whose running address equals its end address completes in the cycle after enable is set, with no memory access.
- R10: A command with reset and bit 6 (init buffer) both set empties the holding register, so `per_out_valid` falls and no stale word is sent.
- R11: A memory request that is not yet accepted stays asserted, with the same address, until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | ADDR_W | Register write data or command word |
| reg_rdata | output | ADDR_W | Selected register or status |
| irq | output | 1 | Completion interrupt, level |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rdata | input | DATA_W | Memory read data, valid with ready |
| mem_err | input | 1 | Bus error, valid with ready |
| per_in_valid | input | 1 | Peripheral word available |
| per_in_data | input | DATA_W | Peripheral word |
| per_in_ready | output | 1 | Channel takes the peripheral word |
| per_out_valid | output | 1 | Word offered to the peripheral |
| per_out_data | output | DATA_W | Word to the peripheral |
| per_out_ready | input | 1 | Peripheral takes the word |

## Verification
The bench builds the channel with ADDR_W of 16 and DATA_W of 32, so the address step is 4. With 16-bit addresses every window fits in a small bench memory, and the saved-end and faulting-address values can be compared exactly. With 32-bit data the word order in both directions can be tied to a counting source and to preloaded memory patterns. It also inserts memory wait states to hold a request open.

// File: rtl/dma_chan_pkg.sv
// Shared constants and types for the chained double-window DMA channel.
// Assumes: command and status words fit in the low bits of the register port.
package dma_chan_pkg;
    localparam int IDX_W = 4;

    localparam logic [IDX_W-1:0] SEL_CTL    = 4'd0;
    localparam logic [IDX_W-1:0] SEL_CUR    = 4'd1;
    localparam logic [IDX_W-1:0] SEL_END    = 4'd2;
    localparam logic [IDX_W-1:0] SEL_QSTART = 4'd3;
    localparam logic [IDX_W-1:0] SEL_QSTOP  = 4'd4;

    localparam int SAVED_BASE = 5;
    localparam int NUM_SAVED  = 4;
    localparam int SV_END_OFS = 1;

    localparam int CMD_RST  = 0;
    localparam int CMD_CLR  = 1;
    localparam int CMD_EN   = 2;
    localparam int CMD_UPD  = 3;
    localparam int CMD_RD   = 4;
    localparam int CMD_WR   = 5;
    localparam int CMD_INIT = 6;
    localparam int CMD_W    = 7;

    localparam int ST_W = 5;

    typedef struct packed {
        logic dir_rd;
        logic buserr;
        logic done;
        logic upd;
        logic en;
    } chan_stat_t;
endpackage

// File: rtl/dma_chan_ctl.sv
// Status flags of the channel: enable, update, complete, bus exception and direction.
// Assumes: hardware events of a cycle take precedence over a command in the same cycle.
module dma_chan_ctl
    import dma_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd,
    input  logic             ev_end,
    input  logic             ev_err,
    output chan_stat_t       stat,
    output logic             flush
);

    // Flush of the holding register needs reset and init-buffer together.
    always_comb begin
        flush = cmd_we && cmd[CMD_RST] && cmd[CMD_INIT];
    end

    // Update status from commands first, then from window and error events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            if (cmd_we) begin
                if (cmd[CMD_RST]) begin
                    stat.en     <= 1'b0;
                    stat.upd    <= 1'b0;
                    stat.done   <= 1'b0;
                    stat.buserr <= 1'b0;
                end
                if (cmd[CMD_CLR]) stat.done <= 1'b0;
                if (cmd[CMD_EN])  stat.en   <= 1'b1;
                if (cmd[CMD_UPD]) stat.upd  <= 1'b1;
                if (cmd[CMD_RD])      stat.dir_rd <= 1'b1;
                else if (cmd[CMD_WR]) stat.dir_rd <= 1'b0;
            end
            if (ev_end) begin
                stat.done <= 1'b1;
                if (stat.upd) stat.upd <= 1'b0;
                else          stat.en  <= 1'b0;
            end
            if (ev_err) begin
                stat.done   <= 1'b1;
                stat.buserr <= 1'b1;
                stat.en     <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dma_chan_win.sv
// Address windows: running/end pair, queued start/stop pair and saved copies.
// Assumes: a software write to a register wins over a hardware update of it.
module dma_chan_win
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                sw_we,
    input  logic [IDX_W-1:0]                    sw_sel,
    input  logic [ADDR_W-1:0]                   sw_data,
    input  logic                                adv,
    input  logic                                chain,
    input  logic                                capture,
    output logic [ADDR_W-1:0]                   cur,
    output logic [ADDR_W-1:0]                   lim,
    output logic [ADDR_W-1:0]                   qstart,
    output logic [ADDR_W-1:0]                   qstop,
    output logic [NUM_SAVED-1:0][ADDR_W-1:0]    saved
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [NUM_SAVED-1:0] sv_we;

    for (genvar g = 0; g < NUM_SAVED; g++) begin : g_sv_sel
        assign sv_we[g] = sw_we && (sw_sel == IDX_W'(SAVED_BASE + g));
    end

    // Running address: software load, chain copy or step after a word.
    always_ff @(posedge clk) begin
        if (!rst_n)                            cur <= '0;
        else if (sw_we && sw_sel == SEL_CUR)   cur <= sw_data;
        else if (chain)                        cur <= qstart;
        else if (adv)                          cur <= cur + STEP_V;
    end

    // End address: software load or chain copy.
    always_ff @(posedge clk) begin
        if (!rst_n)                            lim <= '0;
        else if (sw_we && sw_sel == SEL_END)   lim <= sw_data;
        else if (chain)                        lim <= qstop;
    end

    // Queued window: software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qstart <= '0;
            qstop  <= '0;
        end else if (sw_we) begin
            if (sw_sel == SEL_QSTART) qstart <= sw_data;
            if (sw_sel == SEL_QSTOP)  qstop  <= sw_data;
        end
    end

    // Saved copies; the saved end also captures the final running address.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SAVED; i++) begin
            if (!rst_n)                          saved[i] <= '0;
            else if (sv_we[i])                   saved[i] <= sw_data;
            else if (capture && i == SV_END_OFS) saved[i] <= cur;
        end
    end

endmodule

// File: rtl/dma_chan_mover.sv
// Data path: one-word holding register between peripheral and memory handshakes.
// Assumes: addresses are word aligned and a window length is a multiple of the word size.
module dma_chan_mover #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dir_rd,
    input  logic              flush,
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] lim,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    input  logic              per_in_valid,
    input  logic [DATA_W-1:0] per_in_data,
    output logic              per_in_ready,
    output logic              per_out_valid,
    output logic [DATA_W-1:0] per_out_data,
    input  logic              per_out_ready,
    output logic              ev_adv,
    output logic              ev_err,
    output logic              ev_end
);

    logic [DATA_W-1:0] hold_q;
    logic              full_q;
    logic              live;
    logic              hit;
    logic              take_in;
    logic              give_out;

    // Handshake and event decode from window state and the holding register.
    always_comb begin
        live          = en && (cur != lim);
        ev_end        = en && (cur == lim);
        mem_req       = live && (dir_rd ? full_q : !full_q);
        mem_we        = dir_rd;
        mem_addr      = cur;
        mem_wdata     = hold_q;
        hit           = mem_req && mem_ready;
        ev_err        = hit && mem_err;
        ev_adv        = hit && !mem_err;
        per_in_ready  = live && dir_rd && !full_q;
        take_in       = per_in_valid && per_in_ready;
        per_out_valid = full_q && !dir_rd;
        per_out_data  = hold_q;
        give_out      = per_out_valid && per_out_ready;
    end

    // Occupancy of the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)                               full_q <= 1'b0;
        else if (flush)                           full_q <= 1'b0;
        else if (take_in || (ev_adv && !dir_rd))  full_q <= 1'b1;
        else if ((hit && dir_rd) || give_out)     full_q <= 1'b0;
    end

    // Content of the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hold_q <= '0;
        else if (take_in)           hold_q <= per_in_data;
        else if (ev_adv && !dir_rd) hold_q <= mem_rdata;
    end

endmodule

// File: rtl/dbuf_dma_chan.sv
// Top of the chained double-window DMA channel: register port, status, windows, data path.
// Assumes: register reads are combinational; command bits sit in the low bits of reg_wdata.
module dbuf_dma_chan
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    input  logic              per_in_valid,
    input  logic [DATA_W-1:0] per_in_data,
    output logic              per_in_ready,
    output logic              per_out_valid,
    output logic [DATA_W-1:0] per_out_data,
    input  logic              per_out_ready
);

    localparam int STEP = DATA_W / 8;

    chan_stat_t                          stat;
    logic                                flush;
    logic                                cmd_we;
    logic                                win_we;
    logic                                ev_adv;
    logic                                ev_err;
    logic                                ev_end;
    logic                                chain;
    logic                                st_en;
    logic                                st_upd;
    logic [ADDR_W-1:0]                   cur;
    logic [ADDR_W-1:0]                   lim;
    logic [ADDR_W-1:0]                   qstart;
    logic [ADDR_W-1:0]                   qstop;
    logic [NUM_SAVED-1:0][ADDR_W-1:0]    saved;

    // Split register writes into commands and window loads.
    always_comb begin
        cmd_we = reg_we && (reg_sel == SEL_CTL);
        win_we = reg_we && (reg_sel != SEL_CTL);
        chain  = ev_end && stat.upd;
        st_en  = stat.en;
        st_upd = stat.upd;
        irq    = stat.done;
    end

    dma_chan_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_we (cmd_we),
        .cmd    (reg_wdata[CMD_W-1:0]),
        .ev_end (ev_end),
        .ev_err (ev_err),
        .stat   (stat),
        .flush  (flush)
    );

    dma_chan_win #(.ADDR_W(ADDR_W), .STEP(STEP)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_we   (win_we),
        .sw_sel  (reg_sel),
        .sw_data (reg_wdata),
        .adv     (ev_adv),
        .chain   (chain),
        .capture (ev_end || ev_err),
        .cur     (cur),
        .lim     (lim),
        .qstart  (qstart),
        .qstop   (qstop),
        .saved   (saved)
    );

    dma_chan_mover #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mov (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (stat.en),
        .dir_rd        (stat.dir_rd),
        .flush         (flush),
        .cur           (cur),
        .lim           (lim),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_ready     (mem_ready),
        .mem_rdata     (mem_rdata),
        .mem_err       (mem_err),
        .per_in_valid  (per_in_valid),
        .per_in_data   (per_in_data),
        .per_in_ready  (per_in_ready),
        .per_out_valid (per_out_valid),
        .per_out_data  (per_out_data),
        .per_out_ready (per_out_ready),
        .ev_adv        (ev_adv),
        .ev_err        (ev_err),
        .ev_end        (ev_end)
    );

    // Read mux over status, windows and saved copies.
    always_comb begin
        case (reg_sel)
            SEL_CTL:    reg_rdata = {{(ADDR_W-ST_W){1'b0}}, stat};
            SEL_CUR:    reg_rdata = cur;
            SEL_END:    reg_rdata = lim;
            SEL_QSTART: reg_rdata = qstart;
            SEL_QSTOP:  reg_rdata = qstop;
            4'd5:       reg_rdata = saved[0];
            4'd6:       reg_rdata = saved[1];
            4'd7:       reg_rdata = saved[2];
            4'd8:       reg_rdata = saved[3];
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_chan_chk.sv
// Temporal checks of the channel, attached to the top through a bind.
// Assumes: a register write in the same cycle may override hardware events, so checks exclude it.
module dma_chan_chk #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [3:0]        reg_sel,
    input logic [ADDR_W-1:0] reg_wdata,
    input logic              irq,
    input logic              mem_req,
    input logic              mem_ready,
    input logic              mem_err,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              st_en,
    input logic              st_upd,
    input logic [ADDR_W-1:0] cur,
    input logic [ADDR_W-1:0] lim
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_err && !reg_we) |=> (cur == $past(cur) + STEP_V));

    a_r5_chain_keeps_en: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && cur == lim && st_upd && !reg_we) |=> (st_en && !st_upd && irq));

    a_r6_stop_drops_en: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && cur == lim && !st_upd && !reg_we) |=> (!st_en && irq));

    a_r7_irq_cleared_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_we && reg_sel == 4'd0 && (reg_wdata[0] || reg_wdata[1])));

    a_r8_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_err && !reg_we) |=> (!st_en && irq && cur == $past(cur)));

    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && !reg_we) |=> (mem_req && $stable(mem_addr)));

endmodule

bind dbuf_dma_chan dma_chan_chk #(.ADDR_W(ADDR_W), .STEP(STEP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .mem_err   (mem_err),
    .mem_addr  (mem_addr),
    .st_en     (st_en),
    .st_upd    (st_upd),
    .cur       (cur),
    .lim       (lim)
);

// File: tb/sim_dbuf_dma_chan.sv
module sim_dbuf_dma_chan;
    localparam int AW = 16;
    localparam int DW = 32;

    localparam logic [31:0] S_EN = 32'h01, S_UPD = 32'h02, S_DONE = 32'h04, S_BERR = 32'h08, S_DIR = 32'h10;
    localparam logic [15:0] C_RST = 16'h01, C_CLR = 16'h02, C_EN = 16'h04, C_UPD = 16'h08,
                            C_RD = 16'h10, C_WR = 16'h20, C_INIT = 16'h40;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_sel = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          irq;
    logic          mem_req, mem_we, mem_ready, mem_err;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          per_in_valid = 1'b0;
    logic [DW-1:0] per_in_data;
    logic          per_in_ready;
    logic          per_out_valid;
    logic [DW-1:0] per_out_data;
    logic          per_out_ready = 1'b0;

    logic [31:0]   mem_arr [0:1023];
    logic [31:0]   sink [0:15];
    int            sink_cnt = 0;
    int            mem_hits = 0;
    logic [31:0]   src_word = 32'hA000_0000;
    logic          stall_mode = 1'b0;
    logic          stall_ph = 1'b0;
    logic          err_on = 1'b0;
    logic [AW-1:0] err_addr = '0;
    int            n_chk = 0;
    int            n_fail = 0;

    dbuf_dma_chan #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .per_in_valid(per_in_valid), .per_in_data(per_in_data), .per_in_ready(per_in_ready),
        .per_out_valid(per_out_valid), .per_out_data(per_out_data), .per_out_ready(per_out_ready)
    );

    assign mem_rdata   = mem_arr[mem_addr[11:2]];
    assign mem_ready   = !stall_mode || stall_ph;
    assign mem_err     = err_on && (mem_addr == err_addr);
    assign per_in_data = src_word;

    always @(negedge clk) stall_ph <= ~stall_ph;

    // Bench memory, peripheral source and peripheral sink models.
    always @(posedge clk) begin
        if (mem_req && mem_ready) mem_hits <= mem_hits + 1;
        if (mem_req && mem_ready && mem_we && !mem_err) mem_arr[mem_addr[11:2]] <= mem_wdata;
        if (per_in_valid && per_in_ready) src_word <= src_word + 1;
        if (per_out_valid && per_out_ready) begin
            sink[sink_cnt[3:0]] <= per_out_data;
            sink_cnt <= sink_cnt + 1;
        end
    end

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [AW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [31:0] v);
        reg_sel = s;
        #1;
        v = 32'(reg_rdata);
    endtask

    task automatic wait_irq(input string rq);
        for (int i = 0; i < 400 && !irq; i++) @(negedge clk);
        chk(rq, "interrupt raised", 32'(irq), 32'd1);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(0, v);
        chk("R3", "status after reset pin", v, 32'h0);
        chk("R3", "irq after reset pin", 32'(irq), 32'd0);
        chk("R3", "mem_req after reset pin", 32'(mem_req), 32'd0);
        rd(1, v);
        chk("R3", "running address after reset pin", v, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        for (int k = 1; k <= 8; k++) wr(4'(k), 16'(16'h1100 + 16'(k) * 16'h0104));
        for (int k = 1; k <= 8; k++) begin
            rd(4'(k), v);
            chk("R1", "register readback", v, 32'(16'h1100 + 16'(k) * 16'h0104));
        end
    endtask

    task automatic t_zero_cmd;
        logic [31:0] v;
        wr(0, C_RST | C_CLR);
        wr(0, C_UPD | C_RD);
        rd(0, v);
        chk("R2", "update and read direction set", v, S_UPD | S_DIR);
        wr(0, 16'h0);
        rd(0, v);
        chk("R2", "zero command leaves status", v, S_UPD | S_DIR);
    endtask

    task automatic t_read_stop;
        logic [31:0] v, s0;
        wr(0, C_RST | C_CLR | C_INIT | C_RD);
        wr(1, 16'h0100);
        wr(2, 16'h0110);
        per_in_valid = 1'b1;
        stall_mode = 1'b1;
        s0 = src_word;
        wr(0, C_EN);
        wait_irq("R6");
        rd(0, v);
        chk("R6", "status after stop", v, S_DONE | S_DIR);
        rd(1, v);
        chk("R4", "running address after 4 words", v, 32'h0110);
        rd(6, v);
        chk("R6", "saved end holds final address", v, 32'h0110);
        for (int k = 0; k < 4; k++)
            chk("R4", "peripheral word stored in memory (R11 wait states)", mem_arr[10'h040 + 10'(k)], s0 + 32'(k));
        per_in_valid = 1'b0;
        stall_mode = 1'b0;
    endtask

    task automatic t_chain_write;
        logic [31:0] v;
        logic [31:0] exp_w [0:4];
        for (int k = 0; k < 2; k++) begin
            mem_arr[10'h080 + 10'(k)] = 32'h1111_0000 + 32'(k);
            exp_w[k] = 32'h1111_0000 + 32'(k);
        end
        for (int k = 0; k < 3; k++) begin
            mem_arr[10'h0C0 + 10'(k)] = 32'h2222_0000 + 32'(k);
            exp_w[k + 2] = 32'h2222_0000 + 32'(k);
        end
        wr(0, C_RST | C_CLR | C_INIT | C_WR);
        wr(1, 16'h0200);
        wr(2, 16'h0208);
        wr(3, 16'h0300);
        wr(4, 16'h030C);
        sink_cnt = 0;
        per_out_ready = 1'b1;
        wr(0, C_EN | C_UPD);
        wait_irq("R5");
        rd(0, v);
        chk("R5", "status right after chaining", v, S_EN | S_DONE);
        rd(1, v);
        chk("R5", "running address takes queued start", v, 32'h0300);
        rd(2, v);
        chk("R5", "end address takes queued stop", v, 32'h030C);
        v = S_EN;
        for (int i = 0; i < 400 && v[0]; i++) begin
            @(negedge clk);
            rd(0, v);
        end
        repeat (3) @(negedge clk);
        rd(0, v);
        chk("R6", "status after second window", v, S_DONE);
        chk("R4", "words sent to peripheral", 32'(sink_cnt), 32'd5);
        for (int k = 0; k < 5; k++) chk("R4", "memory word order at peripheral", sink[k], exp_w[k]);
    endtask

    task automatic t_rearm;
        logic [31:0] v;
        wr(0, C_CLR | C_UPD);
        chk("R7", "irq cleared by clear-complete", 32'(irq), 32'd0);
        rd(0, v);
        chk("R7", "update re-armed in same write", v, S_UPD);
    endtask

    task automatic t_empty;
        logic [31:0] v;
        int h0;
        wr(0, C_RST | C_CLR | C_RD);
        wr(1, 16'h0600);
        wr(2, 16'h0600);
        h0 = mem_hits;
        wr(0, C_EN);
        @(negedge clk);
        rd(0, v);
        chk("R9", "empty window completes", v, S_DONE | S_DIR);
        chk("R9", "no memory access", 32'(mem_hits), 32'(h0));
    endtask

    task automatic t_buserr;
        logic [31:0] v, s0;
        wr(0, C_RST | C_CLR | C_INIT | C_RD);
        wr(1, 16'h0400);
        wr(2, 16'h0410);
        mem_arr[10'h102] = 32'hDEAD_0002;
        err_addr = 16'h0408;
        err_on = 1'b1;
        per_in_valid = 1'b1;
        s0 = src_word;
        wr(0, C_EN);
        wait_irq("R8");
        rd(0, v);
        chk("R8", "status after bus error", v, S_DONE | S_BERR | S_DIR);
        rd(1, v);
        chk("R8", "running address holds fault", v, 32'h0408);
        rd(6, v);
        chk("R8", "saved end holds fault", v, 32'h0408);
        chk("R8", "word before fault written", mem_arr[10'h100], s0);
        chk("R8", "faulting word not written", mem_arr[10'h102], 32'hDEAD_0002);
        per_in_valid = 1'b0;
        err_on = 1'b0;
        wr(0, C_RST);
        rd(0, v);
        chk("R3", "reset command clears flags, keeps direction", v, S_DIR);
        chk("R7", "irq cleared by reset command", 32'(irq), 32'd0);
    endtask

    task automatic t_flush;
        logic [31:0] v;
        int c0;
        per_out_ready = 1'b0;
        wr(0, C_RST | C_CLR | C_INIT | C_WR);
        wr(1, 16'h0500);
        wr(2, 16'h0510);
        wr(0, C_EN);
        repeat (4) @(negedge clk);
        chk("R10", "word held for peripheral", 32'(per_out_valid), 32'd1);
        rd(1, v);
        chk("R10", "one word fetched", v, 32'h0504);
        c0 = sink_cnt;
        wr(0, C_RST | C_INIT | C_WR);
        chk("R10", "held word flushed", 32'(per_out_valid), 32'd0);
        per_out_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "no stale word sent", 32'(sink_cnt), 32'(c0));
    endtask

    initial begin
        for (int k = 0; k < 1024; k++) mem_arr[k] = 32'h0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_zero_cmd();
        t_read_stop();
        t_chain_write();
        t_rearm();
        t_empty();
        t_buserr();
        t_flush();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule